// File: doc/BRIEF.md
# Multi-accumulator MAC function unit

This function unit sits beside the ALU of a small 32-bit processor pipeline. It holds four private 72-bit accumulators, so long sums of signed products keep their extra precision and never pass through the general-purpose registers while a sum is being built. Software zeroes an accumulator or loads it from a register. It then issues a run of multiply-accumulate commands and finally moves the result back out, one 32-bit slice at a time. Because every accumulator is independent, two or more dot products can be interleaved command by command.

The decode stage issues at most one command per cycle. A command carries a valid bit, a 2-bit opcode, an accumulator index, a slice selector and two 32-bit operands. The product of a MAC is registered and added one cycle later. A read that arrives while that add is still pending forwards the pending product, so the commands always appear to take effect in program order. Read data comes back through a registered 32-bit word with a valid flag.

Top module: `wacc_unit`

## Requirements
- R1: A synchronous active-high reset zeroes all accumulators and drops `res_valid`; after reset every slice of every accumulator reads 0.
- R2: Opcode 0 (clear) sets the indexed accumulator to zero and leaves the others unchanged.
- R3: Opcode 1 (write) loads the indexed accumulator with `cmd_a` sign-extended from bit 31 to 72 bits.
- R4: Opcode 2 (MAC) adds the signed 64-bit product `cmd_a * cmd_b`, sign-extended to 72 bits, to the indexed accumulator.
- R5: Opcode 3 (read) raises `res_valid` for one cycle, in the cycle after the command. `res_data` then holds bits 31:0 when `cmd_sel` is 0 and bits 63:32 when it is 1. When `cmd_sel` is 2 or 3 it holds bits 71:64, sign-extended from bit 71 to 32 bits.
- R6: A MAC followed directly by another MAC, or by a read of the same accumulator in the next cycle, sees the updated sum.
- R7: A clear or write issued in the cycle after a MAC to the same accumulator overrides that MAC's product.
- R8: When `cmd_valid` is low, the command fields have no effect: no accumulator changes and `res_valid` stays low.
- R9: The accumulators are independent; interleaved MACs to different indices each build their own sum.
- R10: Accumulation wraps modulo 2^72: 512 products of (-2^31)*(-2^31) starting from zero give 2^71, whose high slice reads 0xFFFFFF80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 clear, 1 write, 2 MAC, 3 read |
| cmd_idx | input | 2 | Accumulator index |
| cmd_sel | input | 2 | Read slice: 0 low, 1 middle, 2/3 high |
| cmd_a | input | 32 | First operand (write value or multiplicand) |
| cmd_b | input | 32 | Second operand (multiplier) |
| res_valid | output | 1 | Read result valid |
| res_data | output | 32 | Read result slice |

## Verification
The assertions assume that `rst` is asserted before the first clock edge and that all command fields are driven to known values whenever `cmd_valid` is high; they take no position on the fields while valid is low. The bench drives reset from time zero. It changes inputs only on the falling edge and issues at most one command per cycle. During idle cycles it deliberately places garbage in the opcode, index and operand fields, which exercises the ignore rule without breaking any assumption.

// File: rtl/wacc_pkg.sv
package wacc_pkg;

    typedef enum logic [1:0] {
        OP_CLR = 2'd0,
        OP_WR  = 2'd1,
        OP_MAC = 2'd2,
        OP_RD  = 2'd3
    } wacc_op_e;

    typedef enum logic [1:0] {
        SL_LO  = 2'd0,
        SL_MID = 2'd1,
        SL_HI  = 2'd2,
        SL_HI2 = 2'd3
    } wacc_slice_e;

endpackage

// File: rtl/wacc_mul.sv
module wacc_mul #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 72
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [ACC_W-1:0]  prod_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] a_x, b_x, prod;

    always_comb begin
        a_x  = PROD_W'($signed(a_i));
        b_x  = PROD_W'($signed(b_i));
        prod = a_x * b_x;
    end

    // sign-extend the full product to accumulator width (or truncate if narrower)
    generate
        if (ACC_W > PROD_W) begin : g_ext
            assign prod_o = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end else begin : g_trunc
            assign prod_o = prod[ACC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/wacc_bank.sv
module wacc_bank #(
    parameter int N_ACC = 4,
    parameter int ACC_W = 72,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        add_en,
    input  logic [IDX_W-1:0]            add_idx,
    input  logic [ACC_W-1:0]            add_val,
    input  logic                        set_en,
    input  logic [IDX_W-1:0]            set_idx,
    input  logic [ACC_W-1:0]            set_val,
    output logic [N_ACC-1:0][ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic [N_ACC-1:0][ACC_W-1:0] acc;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (add_en) begin
            st_d.acc[add_idx] = st_q.acc[add_idx] + add_val;
        end
        // a set is the younger command: it overrides a pending add to the same entry
        if (set_en) begin
            st_d.acc[set_idx] = set_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    // R3, R7: a clear/write always lands, even over a pending product
    a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_en |=> acc_o[$past(set_idx)] == $past(set_val));

    // R4: a pending product is added when no set targets the same entry
    a_r4_acc_adds: assert property (@(posedge clk) disable iff (rst)
        (add_en && !(set_en && set_idx == add_idx))
        |=> acc_o[$past(add_idx)] == $past(acc_o[add_idx] + add_val));

endmodule

// File: rtl/wacc_rdsel.sv
module wacc_rdsel import wacc_pkg::*; #(
    parameter int N_ACC  = 4,
    parameter int ACC_W  = 72,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [N_ACC-1:0][ACC_W-1:0] acc_i,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [1:0]                  rd_sel,
    input  logic                        fwd_en,
    input  logic [IDX_W-1:0]            fwd_idx,
    input  logic [ACC_W-1:0]            fwd_val,
    output logic [DATA_W-1:0]           word_o
);
    localparam int HI_W = ACC_W - 2 * DATA_W;

    logic [ACC_W-1:0] cur;
    wacc_slice_e      sel;

    always_comb begin
        cur = acc_i[rd_idx];
        // forward the product still waiting to be added
        if (fwd_en && fwd_idx == rd_idx) begin
            cur = cur + fwd_val;
        end
        sel = wacc_slice_e'(rd_sel);
        case (sel)
            SL_LO:   word_o = cur[DATA_W-1:0];
            SL_MID:  word_o = cur[2*DATA_W-1:DATA_W];
            default: word_o = {{(DATA_W-HI_W){cur[ACC_W-1]}}, cur[ACC_W-1:2*DATA_W]};
        endcase
    end

endmodule

// File: rtl/wacc_unit.sv
module wacc_unit import wacc_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 72,
    parameter int N_ACC  = 4,
    localparam int IDX_W = $clog2(N_ACC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [1:0]        cmd_sel,
    input  logic [DATA_W-1:0] cmd_a,
    input  logic [DATA_W-1:0] cmd_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    localparam int HI_W = ACC_W - 2 * DATA_W;

    typedef struct packed {
        logic              pend_v;
        logic [IDX_W-1:0]  pend_idx;
        logic [ACC_W-1:0]  pend_val;
        logic              res_v;
        logic [DATA_W-1:0] res_d;
    } unit_s;

    unit_s                       st_d, st_q;
    wacc_op_e                    op;
    logic                        is_clr, is_wr, is_mac, is_rd;
    logic                        set_en;
    logic [ACC_W-1:0]            set_val;
    logic [ACC_W-1:0]            prod_ext;
    logic [N_ACC-1:0][ACC_W-1:0] acc_all;
    logic [DATA_W-1:0]           rd_word;

    always_comb begin
        op      = wacc_op_e'(cmd_op);
        is_clr  = cmd_valid && (op == OP_CLR);
        is_wr   = cmd_valid && (op == OP_WR);
        is_mac  = cmd_valid && (op == OP_MAC);
        is_rd   = cmd_valid && (op == OP_RD);
        set_en  = is_clr || is_wr;
        set_val = is_wr ? {{(ACC_W-DATA_W){cmd_a[DATA_W-1]}}, cmd_a} : '0;
    end

    wacc_mul #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mul (
        .a_i    (cmd_a),
        .b_i    (cmd_b),
        .prod_o (prod_ext)
    );

    wacc_bank #(.N_ACC(N_ACC), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .add_en  (st_q.pend_v),
        .add_idx (st_q.pend_idx),
        .add_val (st_q.pend_val),
        .set_en  (set_en),
        .set_idx (cmd_idx),
        .set_val (set_val),
        .acc_o   (acc_all)
    );

    wacc_rdsel #(.N_ACC(N_ACC), .ACC_W(ACC_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdsel (
        .acc_i   (acc_all),
        .rd_idx  (cmd_idx),
        .rd_sel  (cmd_sel),
        .fwd_en  (st_q.pend_v),
        .fwd_idx (st_q.pend_idx),
        .fwd_val (st_q.pend_val),
        .word_o  (rd_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pend_v = is_mac;
        if (is_mac) begin
            st_d.pend_idx = cmd_idx;
            st_d.pend_val = prod_ext;
        end
        st_d.res_v = is_rd;
        if (is_rd) begin
            st_d.res_d = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.res_v;
    assign res_data  = st_q.res_d;

    // R1: reset leaves every accumulator at zero and no result pending
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_valid && acc_all == '0));

    // R2: clear zeroes the addressed entry
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0) |=> acc_all[$past(cmd_idx)] == '0);

    // R5: a read produces a result one cycle later
    a_r5_rd_valid: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd3) |=> res_valid);

    // R5: high slice is sign-extended
    a_r5_hi_sext: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd3 && cmd_sel[1])
        |=> res_data[DATA_W-1:HI_W] == {(DATA_W-HI_W){res_data[HI_W-1]}});

    // R8: no read command, no result
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 2'd3) |=> !res_valid);

    // R8: idle cycles with nothing pending keep the bank still
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && !st_q.pend_v) |=> $stable(acc_all));

endmodule

// File: tb/wacc_unit_tb.sv
`timescale 1ns/1ps
module wacc_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_idx;
    logic [1:0]  cmd_sel;
    logic [31:0] cmd_a;
    logic [31:0] cmd_b;
    logic        res_valid;
    logic [31:0] res_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [71:0] m_acc [4];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    always #2 clk = ~clk;

    wacc_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_sel   (cmd_sel),
        .cmd_a     (cmd_a),
        .cmd_b     (cmd_b),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    function automatic logic [31:0] slc(logic [71:0] v, logic [1:0] s);
        case (s)
            2'd0:    return v[31:0];
            2'd1:    return v[63:32];
            default: return {{24{v[71]}}, v[71:64]};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one command per falling edge, model updated in program order
    task automatic issue(input logic [1:0] op, input int idx, input logic [1:0] sel,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        logic signed [63:0] p;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = 2'(idx);
        cmd_sel   = sel;
        cmd_a     = a;
        cmd_b     = b;
        case (op)
            2'd0: m_acc[idx] = '0;
            2'd1: m_acc[idx] = {{40{a[31]}}, a};
            2'd2: begin
                p = 64'($signed(a)) * 64'($signed(b));
                m_acc[idx] = m_acc[idx] + {{8{p[63]}}, p};
            end
            default: begin
                q_data.push_back(slc(m_acc[idx], sel));
                q_tag.push_back(tag);
            end
        endcase
    endtask

    task automatic idle(input logic [1:0] op, input logic [31:0] junk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = op;
        cmd_idx   = junk[1:0];
        cmd_sel   = junk[3:2];
        cmd_a     = junk;
        cmd_b     = ~junk;
    endtask

    task automatic rd_all(input int idx, input string tag);
        for (int s = 0; s < 3; s++) issue(2'd3, idx, 2'(s), 32'h0, 32'h0, tag);
    endtask

    // monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (!rst && res_valid && !done) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R8 unexpected result", res_data, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = q_data.pop_front();
                t = q_tag.pop_front();
                chk(res_data === e, t, res_data, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_idx = '0;
        cmd_sel = '0; cmd_a = '0; cmd_b = '0;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 res_valid in reset", {31'b0, res_valid}, 32'h0);
        rst = 1'b0;

        // R1: all entries read zero
        for (int i = 0; i < 4; i++) rd_all(i, "R1 reset value");

        // R3: write sign-extends
        issue(2'd1, 0, 2'd0, 32'hFFFF_FFFB, 32'h0, "R3");
        rd_all(0, "R3 write negative");
        issue(2'd1, 1, 2'd0, 32'h7FFF_FFFF, 32'h0, "R3");
        rd_all(1, "R3 write positive");

        // R2: clear one, the other untouched
        issue(2'd0, 0, 2'd0, 32'h0, 32'h0, "R2");
        rd_all(0, "R2 cleared");
        rd_all(1, "R2 neighbour kept");

        // R4/R6: back-to-back MACs with forwarded read
        issue(2'd0, 2, 2'd0, 32'h0, 32'h0, "R4");
        issue(2'd2, 2, 2'd0, 32'd3, 32'hFFFF_FFF9, "R4");
        issue(2'd2, 2, 2'd0, 32'd100, 32'd5, "R4");
        issue(2'd2, 2, 2'd0, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
        issue(2'd3, 2, 2'd0, 32'h0, 32'h0, "R6 forward lo");
        issue(2'd3, 2, 2'd2, 32'h0, 32'h0, "R6 hi");
        issue(2'd2, 2, 2'd0, 32'h1234_5678, 32'h9ABC_DEF0, "R4");
        issue(2'd3, 2, 2'd1, 32'h0, 32'h0, "R6 forward mid");
        issue(2'd3, 2, 2'd3, 32'h0, 32'h0, "R5 sel3 hi");

        // R9: interleaved dot products
        issue(2'd0, 0, 2'd0, 32'h0, 32'h0, "R9");
        issue(2'd0, 1, 2'd0, 32'h0, 32'h0, "R9");
        for (int k = 0; k < 20; k++) begin
            issue(2'd2, k % 2, 2'd0, $urandom, $urandom, "R9");
        end
        issue(2'd2, 3, 2'd0, 32'd7, 32'd9, "R9");
        issue(2'd3, 0, 2'd1, 32'h0, 32'h0, "R9 no forward across index");
        rd_all(0, "R9 acc0");
        rd_all(1, "R9 acc1");

        // R7: younger clear/write wins over pending product
        issue(2'd2, 3, 2'd0, 32'd1000, 32'd1000, "R7");
        issue(2'd0, 3, 2'd0, 32'h0, 32'h0, "R7");
        rd_all(3, "R7 clear over MAC");
        issue(2'd2, 3, 2'd0, 32'd77, 32'd77, "R7");
        issue(2'd1, 3, 2'd0, 32'h8000_0001, 32'h0, "R7");
        rd_all(3, "R7 write over MAC");

        // R8: valid low with garbage fields
        idle(2'd2, 32'hDEAD_BEEF);
        idle(2'd0, 32'h5555_5556);
        idle(2'd1, 32'hAAAA_AAA9);
        idle(2'd3, 32'h0000_0003);
        @(negedge clk);
        chk(res_valid == 1'b0, "R8 no result when invalid", {31'b0, res_valid}, 32'h0);
        for (int i = 0; i < 4; i++) rd_all(i, "R8 state kept");

        // R10: wrap to 2^71
        issue(2'd0, 3, 2'd0, 32'h0, 32'h0, "R10");
        for (int k = 0; k < 512; k++) issue(2'd2, 3, 2'd0, 32'h8000_0000, 32'h8000_0000, "R10");
        rd_all(3, "R10 wrap");
        chk(slc(m_acc[3], 2'd2) == 32'hFFFF_FF80, "R10 model", slc(m_acc[3], 2'd2), 32'hFFFF_FF80);

        idle(2'd0, 32'h0);
        repeat (4) @(negedge clk);
        chk(q_data.size() == 0, "R5 all reads answered", q_data.size(), 32'h0);
        finish_run();
    end

endmodule